// File: doc/BRIEF.md
# Per-Pin GPIO Controller with Fixed Interrupt Pins

This block is a byte-addressed GPIO peripheral with a 48-byte register window. The lowest eight bytes are read-only snapshots of a 64-bit level input bus. The next 36 bytes each hold the state of one pin:

- an output-enable bit,
- an output data bit,
- an input level bit.

Writing a pin byte with output enable set loops the written output data bit back into that pin's level bit. Writing it with output enable clear leaves the level bit alone.

External logic reports new input levels through a pin-event stream. An event replaces only the level bit of the named pin. If the pin is currently driving, the event still lands, but it also sets a sticky error flag.

Two pins have fixed interrupt meanings:

- Pin 1 raises an active-low level interrupt.
- Pin 9's interrupt follows its level high. A non-maskable-interrupt request drives pin 9 high and then low, which gives a pulse lasting exactly one cycle.

The remaining eight of the ten interrupt outputs stay low.

Both the bus and the event port use valid/ready. A request moves only in a cycle where both are high, and a source must hold its fields stable until then. The bus stalls (`bus_ready` low) while a request from the non-maskable-interrupt input is being played out. The event port stalls during that sequence, and also in any cycle that carries a bus write, so a pin byte is never updated from two sources in one cycle. Read data comes back with `rsp_valid` in the cycle after the read is taken, and it cannot be back-pressured.

Top module: `gpio_pin_ctrl`

## Requirements
- R1: After reset, every pin byte reads 0x00 except pin 1, which reads 0x02. `irq` is all zero, `err_flag` is 0 and `bus_ready` is 1.
- R2: A read at offset k in 0..7 returns `level_in[8k+7:8k]`. Writes at offsets 0..7 change no register.
- R3: Offset 8+p, for p in 0..35, reads and writes the byte of pin p. Bits 7..3 hold what was last written.
- R4: A write of value d to a pin byte stores d[7:2] and d[0]. Bit 1 becomes d[0] when d[2] is 1, and keeps its old value when d[2] is 0.
- R5: An accepted event with pin p and level L sets bit 1 of pin p's byte to L and leaves every other bit unchanged.
- R6: An accepted event on a pin whose bit 2 is 1 still updates bit 1, and it sets `err_flag`. `err_flag` stays at 1 until reset.
- R7: `irq[1]` is 1 exactly while bit 1 of pin 1's byte is 0.
- R8: `irq[9]` equals bit 1 of pin 9's byte. A request accepted on `nmi_req` (when `bus_ready` is 1) sets that bit to 1 two edges later and clears it on the edge after, so `irq[9]` is high for one cycle and the bit ends at 0.
- R9: `irq` bits other than 1 and 9 are always 0.
- R10: Reads at offsets 44..47 return 0x00. Writes there change no register.
- R11: A read taken at an edge gives `rsp_valid` = 1 for the following cycle only. `bus_ready` is 0 for the two cycles after an accepted `nmi_req`. `evt_ready` is 0 whenever `bus_valid` and `bus_write` are both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus request present |
| bus_ready | output | 1 | Bus request can be taken |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset in the window |
| bus_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 8 | Read data |
| evt_valid | input | 1 | Pin event present |
| evt_ready | output | 1 | Pin event can be taken |
| evt_pin | input | 6 | Pin index of the event |
| evt_level | input | 1 | New input level for the pin |
| nmi_req | input | 1 | Non-maskable-interrupt request |
| level_in | input | 64 | Source of the eight read-only level bytes |
| irq | output | 10 | Interrupt outputs |
| err_flag | output | 1 | Sticky flag for an event on a driven pin |

## Verification
A corrupted pin byte shows at the read port on the first read of its offset, one cycle after that read is taken. A corrupted level bit on pin 1 or pin 9 shows at `irq` in the cycle right after the faulty edge. The bench therefore writes and reads back every pin byte under all eight low-bit patterns, and it checks `irq` after every step. A wrong sequencer state shows within three cycles, either as a missing or stretched pulse on `irq[9]` or as a `bus_ready` that stays stuck low.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int BYTE_W  = 8;
  localparam int BIT_OUT = 0;
  localparam int BIT_LVL = 1;
  localparam int BIT_OE  = 2;

  typedef enum logic [1:0] {
    NMI_IDLE = 2'd0,
    NMI_RISE = 2'd1,
    NMI_FALL = 2'd2
  } nmi_phase_e;
endpackage

// File: rtl/gpio_pin_file.sv
module gpio_pin_file #(
  parameter int NUM_PINS    = 36,
  parameter int IDX_W       = 6,
  parameter int PRESET_PIN  = 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [IDX_W-1:0]               wr_idx,
  input  logic [gpio_pkg::BYTE_W-1:0]    wr_data,
  input  logic                           ev_en,
  input  logic [IDX_W-1:0]               ev_idx,
  input  logic                           ev_level,
  output logic [NUM_PINS*gpio_pkg::BYTE_W-1:0] pin_bytes,
  output logic                           ev_oe_hit
);
  import gpio_pkg::*;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam logic [BYTE_W-1:0] RST_VAL =
      (p == PRESET_PIN) ? (BYTE_W'(1) << BIT_LVL) : '0;
    logic [BYTE_W-1:0] q;
    logic              hit_wr, hit_ev;
    logic              loop_lvl;

    assign hit_wr   = wr_en && (wr_idx == IDX_W'(p));
    assign hit_ev   = ev_en && (ev_idx == IDX_W'(p));
    assign loop_lvl = wr_data[BIT_OE] ? wr_data[BIT_OUT] : q[BIT_LVL];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= RST_VAL;
      end else if (hit_wr) begin
        q <= {wr_data[BYTE_W-1:BIT_LVL+1], loop_lvl, wr_data[BIT_OUT]};
      end else if (hit_ev) begin
        q[BIT_LVL] <= ev_level;
      end
    end

    assign pin_bytes[p*BYTE_W +: BYTE_W] = q;
  end

  always_comb begin
    ev_oe_hit = 1'b0;
    for (int i = 0; i < NUM_PINS; i++) begin
      if (ev_en && (ev_idx == IDX_W'(i)) && pin_bytes[i*BYTE_W + BIT_OE]) begin
        ev_oe_hit = 1'b1;
      end
    end
  end
endmodule

// File: rtl/gpio_rd_path.sv
module gpio_rd_path #(
  parameter int NUM_LVL  = 8,
  parameter int NUM_PINS = 36,
  parameter int ADDR_W   = 6
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                rd_en,
  input  logic [ADDR_W-1:0]                   addr,
  input  logic [NUM_LVL*gpio_pkg::BYTE_W-1:0] level_in,
  input  logic [NUM_PINS*gpio_pkg::BYTE_W-1:0] pin_bytes,
  output logic                                rsp_valid,
  output logic [gpio_pkg::BYTE_W-1:0]         rsp_rdata
);
  import gpio_pkg::*;

  logic [BYTE_W-1:0] sel;

  always_comb begin
    sel = '0;
    for (int i = 0; i < NUM_LVL; i++) begin
      if (addr == ADDR_W'(i)) sel = level_in[i*BYTE_W +: BYTE_W];
    end
    for (int j = 0; j < NUM_PINS; j++) begin
      if (addr == ADDR_W'(NUM_LVL + j)) sel = pin_bytes[j*BYTE_W +: BYTE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_en;
      if (rd_en) rsp_rdata <= sel;
    end
  end
endmodule

// File: rtl/gpio_nmi_seq.sv
module gpio_nmi_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_req,
  output logic busy,
  output logic drive_en,
  output logic drive_level
);
  import gpio_pkg::*;

  nmi_phase_e phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= NMI_IDLE;
    end else begin
      unique case (phase_q)
        NMI_IDLE: if (nmi_req) phase_q <= NMI_RISE;
        NMI_RISE: phase_q <= NMI_FALL;
        NMI_FALL: phase_q <= NMI_IDLE;
        default:  phase_q <= NMI_IDLE;
      endcase
    end
  end

  assign busy        = (phase_q != NMI_IDLE);
  assign drive_en    = busy;
  assign drive_level = (phase_q == NMI_RISE);
endmodule

// File: rtl/gpio_irq_map.sv
module gpio_irq_map #(
  parameter int NUM_PINS  = 36,
  parameter int NUM_IRQ   = 10,
  parameter int LOW_PIN   = 1,
  parameter int PULSE_PIN = 9
) (
  input  logic [NUM_PINS*gpio_pkg::BYTE_W-1:0] pin_bytes,
  output logic [NUM_IRQ-1:0]                   irq
);
  import gpio_pkg::*;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
    if (i == LOW_PIN) begin : g_low
      assign irq[i] = ~pin_bytes[i*BYTE_W + BIT_LVL];
    end else if (i == PULSE_PIN) begin : g_high
      assign irq[i] = pin_bytes[i*BYTE_W + BIT_LVL];
    end else begin : g_none
      assign irq[i] = 1'b0;
    end
  end
endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl #(
  parameter int NUM_LVL   = 8,
  parameter int NUM_PINS  = 36,
  parameter int WIN_BYTES = 48,
  parameter int NUM_IRQ   = 10,
  parameter int LOW_PIN   = 1,
  parameter int PULSE_PIN = 9,
  localparam int ADDR_W   = $clog2(WIN_BYTES),
  localparam int IDX_W    = $clog2(NUM_PINS),
  localparam int LVL_W    = NUM_LVL * gpio_pkg::BYTE_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_valid,
  output logic                        bus_ready,
  input  logic                        bus_write,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [gpio_pkg::BYTE_W-1:0] bus_wdata,
  output logic                        rsp_valid,
  output logic [gpio_pkg::BYTE_W-1:0] rsp_rdata,
  input  logic                        evt_valid,
  output logic                        evt_ready,
  input  logic [IDX_W-1:0]            evt_pin,
  input  logic                        evt_level,
  input  logic                        nmi_req,
  input  logic [LVL_W-1:0]            level_in,
  output logic [NUM_IRQ-1:0]          irq,
  output logic                        err_flag
);
  import gpio_pkg::*;

  localparam logic [ADDR_W-1:0] PIN_BASE = ADDR_W'(NUM_LVL);
  localparam logic [ADDR_W-1:0] PIN_END  = ADDR_W'(NUM_LVL + NUM_PINS);

  logic                        nmi_busy, nmi_drive, nmi_level;
  logic                        bus_fire, wr_en, rd_en, in_pins;
  logic [IDX_W-1:0]            wr_idx;
  logic                        ext_ev, ev_en, ev_level, ev_oe_hit;
  logic [IDX_W-1:0]            ev_idx;
  logic [NUM_PINS*BYTE_W-1:0]  pin_bytes;

  gpio_nmi_seq u_nmi (
    .clk        (clk),
    .rst_n      (rst_n),
    .nmi_req    (nmi_req),
    .busy       (nmi_busy),
    .drive_en   (nmi_drive),
    .drive_level(nmi_level)
  );

  assign bus_ready = !nmi_busy;
  assign evt_ready = !nmi_busy && !(bus_valid && bus_write);
  assign bus_fire  = bus_valid && bus_ready;
  assign in_pins   = (bus_addr >= PIN_BASE) && (bus_addr < PIN_END);
  assign wr_en     = bus_fire && bus_write && in_pins;
  assign rd_en     = bus_fire && !bus_write;
  assign wr_idx    = IDX_W'(bus_addr - PIN_BASE);

  assign ext_ev   = evt_valid && evt_ready && (evt_pin < IDX_W'(NUM_PINS));
  assign ev_en    = nmi_drive || ext_ev;
  assign ev_idx   = nmi_drive ? IDX_W'(PULSE_PIN) : evt_pin;
  assign ev_level = nmi_drive ? nmi_level : evt_level;

  gpio_pin_file #(
    .NUM_PINS  (NUM_PINS),
    .IDX_W     (IDX_W),
    .PRESET_PIN(LOW_PIN)
  ) u_pins (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (bus_wdata),
    .ev_en    (ev_en),
    .ev_idx   (ev_idx),
    .ev_level (ev_level),
    .pin_bytes(pin_bytes),
    .ev_oe_hit(ev_oe_hit)
  );

  gpio_rd_path #(
    .NUM_LVL (NUM_LVL),
    .NUM_PINS(NUM_PINS),
    .ADDR_W  (ADDR_W)
  ) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .addr     (bus_addr),
    .level_in (level_in),
    .pin_bytes(pin_bytes),
    .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata)
  );

  gpio_irq_map #(
    .NUM_PINS (NUM_PINS),
    .NUM_IRQ  (NUM_IRQ),
    .LOW_PIN  (LOW_PIN),
    .PULSE_PIN(PULSE_PIN)
  ) u_irq (
    .pin_bytes(pin_bytes),
    .irq      (irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         err_flag <= 1'b0;
    else if (ev_oe_hit) err_flag <= 1'b1;
  end
endmodule

// File: rtl/gpio_pin_ctrl_chk.sv
module gpio_pin_ctrl_chk #(
  parameter int NUM_IRQ   = 10,
  parameter int LOW_PIN   = 1,
  parameter int PULSE_PIN = 9
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_valid,
  input logic               bus_ready,
  input logic               bus_write,
  input logic               rsp_valid,
  input logic               evt_ready,
  input logic               nmi_req,
  input logic [NUM_IRQ-1:0] irq,
  input logic               err_flag
);
  logic [NUM_IRQ-1:0] used_mask;
  always_comb begin
    used_mask = '0;
    used_mask[LOW_PIN]   = 1'b1;
    used_mask[PULSE_PIN] = 1'b1;
  end

  AST_BUS_EVT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && bus_write && evt_ready)); // R11
  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_ready && !bus_write) |=> rsp_valid); // R11
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && bus_ready && !bus_write) |=> !rsp_valid); // R11
  AST_NMI_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_req && bus_ready) |=> !bus_ready ##1 !bus_ready); // R11
  AST_NMI_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_req && bus_ready) |=> ##1 irq[PULSE_PIN] ##1 !irq[PULSE_PIN]); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag); // R6
  AST_UNUSED_IRQ_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (irq & ~used_mask) == '0); // R9
endmodule

bind gpio_pin_ctrl gpio_pin_ctrl_chk #(
  .NUM_IRQ  (NUM_IRQ),
  .LOW_PIN  (LOW_PIN),
  .PULSE_PIN(PULSE_PIN)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_valid(bus_valid),
  .bus_ready(bus_ready),
  .bus_write(bus_write),
  .rsp_valid(rsp_valid),
  .evt_ready(evt_ready),
  .nmi_req  (nmi_req),
  .irq      (irq),
  .err_flag (err_flag)
);

// File: tb/gpio_pin_ctrl_test.sv
module gpio_pin_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_ready, rsp_valid, evt_ready, err_flag;
  logic [7:0]  rsp_rdata;
  logic        evt_valid = 1'b0, evt_level = 1'b0, nmi_req = 1'b0;
  logic [5:0]  evt_pin = '0;
  logic [63:0] level_in = 64'h0123_4567_89AB_CDEF;
  logic [9:0]  irq;

  always #2 clk = ~clk;

  gpio_pin_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .evt_valid(evt_valid),
    .evt_ready(evt_ready), .evt_pin(evt_pin), .evt_level(evt_level),
    .nmi_req(nmi_req), .level_in(level_in), .irq(irq), .err_flag(err_flag)
  );

  logic [7:0] exp_b [36];
  logic       exp_err = 1'b0;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  task automatic chk(string req, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [7:0] exp_rd(int a);
    if (a < 8)  return level_in[a*8 +: 8];
    if (a < 44) return exp_b[a-8];
    return 8'h00;
  endfunction

  function automatic logic [9:0] exp_irq();
    logic [9:0] v = '0;
    v[1] = ~exp_b[1][1];
    v[9] = exp_b[9][1];
    return v;
  endfunction

  task automatic wr(int a, logic [7:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 6'(a); bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    if (a >= 8 && a < 44)
      exp_b[a-8] = {d[7:2], d[2] ? d[0] : exp_b[a-8][1], d[0]};
  endtask

  task automatic rd_chk(string req, int a);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 6'(a);
    @(negedge clk);
    bus_valid = 1'b0;
    chk({req, " rsp_valid"}, 64'(rsp_valid), 64'd1);
    chk(req, 64'(rsp_rdata), 64'(exp_rd(a)));
  endtask

  task automatic ev(int p, logic l);
    @(negedge clk);
    evt_valid = 1'b1; evt_pin = 6'(p); evt_level = l;
    @(negedge clk);
    evt_valid = 1'b0;
    if (exp_b[p][2]) exp_err = 1'b1;
    exp_b[p][1] = l;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R1-R11 actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 36; i++) exp_b[i] = 8'h00;
    exp_b[1] = 8'h02;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    chk("R1 irq", 64'(irq), 64'd0);
    chk("R1 err_flag", 64'(err_flag), 64'd0);
    chk("R1 bus_ready", 64'(bus_ready), 64'd1);
    for (int a = 8; a < 44; a++) rd_chk("R1 reset byte", a);

    // R2 level bytes read-only
    for (int a = 0; a < 8; a++) rd_chk("R2 level read", a);
    for (int a = 0; a < 8; a++) wr(a, 8'hFF);
    for (int a = 0; a < 44; a++) rd_chk("R2 after level write", a);
    level_in = 64'hFEDC_BA98_7654_3210;
    for (int a = 0; a < 8; a++) rd_chk("R2 level read 2", a);

    // R3 R4 R7 R9 write sweep, last write per pin has bit2 clear
    for (int p = 0; p < 36; p++) begin
      for (int v = 7; v >= 0; v--) begin
        wr(8 + p, {p[4:0], v[2:0]});
        rd_chk("R3 R4 pin write", 8 + p);
        chk("R7 R9 irq after write", 64'(irq), 64'(exp_irq()));
      end
    end

    // R5 events on every pin
    for (int p = 0; p < 36; p++) begin
      ev(p, 1'b1); rd_chk("R5 event high", 8 + p);
      chk("R7 R9 irq after event", 64'(irq), 64'(exp_irq()));
      ev(p, 1'b1); rd_chk("R5 repeat event", 8 + p);
      ev(p, 1'b0); rd_chk("R5 event low", 8 + p);
      chk("R7 R9 irq after event", 64'(irq), 64'(exp_irq()));
    end
    chk("R6 no error without drive", 64'(err_flag), 64'd0);

    // R6 event on a driven pin
    wr(8 + 20, 8'h04);
    ev(20, 1'b1);
    rd_chk("R6 driven pin updated", 8 + 20);
    chk("R6 err set", 64'(err_flag), 64'(exp_err));
    ev(5, 1'b1);
    chk("R6 err sticky", 64'(err_flag), 64'd1);

    // R7 pin 1 active-low
    ev(1, 1'b0);
    chk("R7 irq1 low level", 64'(irq[1]), 64'd1);
    ev(1, 1'b1);
    chk("R7 irq1 high level", 64'(irq[1]), 64'd0);

    // R10 unmapped tail
    for (int a = 44; a < 48; a++) rd_chk("R10 tail read", a);
    for (int a = 44; a < 48; a++) wr(a, 8'hFF);
    for (int a = 8; a < 48; a++) rd_chk("R10 after tail write", a);

    // R8 R11 NMI pulse
    ev(9, 1'b0);
    @(negedge clk) nmi_req = 1'b1;
    @(negedge clk) nmi_req = 1'b0;
    chk("R11 stall 1", 64'(bus_ready), 64'd0);
    chk("R8 irq9 phase 1", 64'(irq[9]), 64'd0);
    @(negedge clk);
    chk("R11 stall 2", 64'(bus_ready), 64'd0);
    chk("R8 irq9 pulse", 64'(irq[9]), 64'd1);
    @(negedge clk);
    chk("R11 ready again", 64'(bus_ready), 64'd1);
    chk("R8 irq9 after pulse", 64'(irq[9]), 64'd0);
    exp_b[9][1] = 1'b0;
    rd_chk("R8 pin9 byte", 8 + 9);

    // R11 event stalled by a bus write
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 6'(8 + 3); bus_wdata = 8'h00;
    evt_valid = 1'b1; evt_pin = 6'd3; evt_level = 1'b1;
    #1 chk("R11 evt_ready during write", 64'(evt_ready), 64'd0);
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0; evt_valid = 1'b0;
    exp_b[3] = {6'd0, exp_b[3][1], 1'b0};
    rd_chk("R11 stalled event not applied", 8 + 3);
    @(negedge clk);
    chk("R11 rsp one cycle", 64'(rsp_valid), 64'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule